// File: doc/BRIEF.md
# Staged Multicycle Processor Datapath

This block is the 32-bit datapath of a small multicycle processor. It runs six instructions: register add, register subtract, OR with an immediate, word load, word store and branch-if-equal. Each instruction passes through several clock cycles. Between those cycles it is held in staging registers: an instruction register, two operand latches (A and B), an ALU result latch (S) and a load data latch (M). The block contains the program counter, a register file with 32 entries of 32 bits, the ALU, the zero and sign extension of the 16-bit immediate, and the branch target adder.

There is no sequencer inside the block. An external controller drives a load enable for each staging register, the ALU operand select, and the register-file, memory-write and PC-update controls, one cycle per step. The datapath gives back the opcode of the held instruction and an operand-equality flag for the controller to use. Instructions are fetched at the PC through the instruction port. The data port takes its address straight from S and its write data from B. Reads on both ports return data within the same cycle. A store writes at the clock edge while the write strobe is high.

Top module: `staged_dp`

## Requirements
- R1: While reset is low, the PC, the instruction register, A, B, S, M and every register-file entry are cleared, so `imem_addr`, `dmem_addr`, `dmem_wdata` and `op_code` read zero.
- R2: With `ir_ld` high, the instruction register captures `imem_rdata` at the clock edge. `op_code` shows its bits 31:26. The other fields are source register rs at bits 25:21, second register rt at bits 20:16, destination rd at bits 15:11, the immediate at bits 15:0 and the function code at bits 5:0.
- R3: With `opf_ld` high, A captures register rs and B captures register rt. `opnd_eq` is high exactly when A equals B.
- R4: With `s_ld` high and `alu_sel` = 00, S captures A minus B when the function code is 100011, and A plus B for 100001 or any other code.
- R5: With `s_ld` high and `alu_sel` = 01, S captures A OR the zero-extended immediate.
- R6: With `s_ld` high and `alu_sel` = 10 or 11, S captures A plus the sign-extended immediate. `dmem_addr` always shows S.
- R7: `dmem_wdata` always shows B and `dmem_we` follows `mem_wr` in the same cycle. With `m_ld` high, M captures `dmem_rdata`.
- R8: With `rf_we` high, the register file writes at the edge. The destination is rd when `rf_wdst` is 1 and rt when it is 0. The data is M when `rf_wsrc` is 1 and S when it is 0.
- R9: Register 0 reads as zero, and writes to it have no effect.
- R10: With `pc_ld` high and `pc_br` low, the PC advances by 4.
- R11: With `pc_ld` and `pc_br` high, the PC becomes PC + 4 + (sign-extended immediate shifted left by 2) when A equals B, and PC + 4 otherwise.
- R12: The PC, the instruction register, A, B, S and M hold their value in every cycle where their own load enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_ld | input | 1 | Load instruction register from instruction port |
| opf_ld | input | 1 | Load A and B from the register file |
| s_ld | input | 1 | Load S from the ALU |
| alu_sel | input | 2 | ALU operand and operation select |
| m_ld | input | 1 | Load M from data read port |
| mem_wr | input | 1 | Data memory write request |
| rf_we | input | 1 | Register file write enable |
| rf_wdst | input | 1 | Write destination: 1 = rd, 0 = rt |
| rf_wsrc | input | 1 | Write data: 1 = M, 0 = S |
| pc_ld | input | 1 | Update PC |
| pc_br | input | 1 | PC update is a conditional branch |
| imem_addr | output | 32 | Instruction fetch address (PC) |
| imem_rdata | input | 32 | Instruction read data |
| dmem_addr | output | 32 | Data address (S) |
| dmem_wdata | output | 32 | Data write value (B) |
| dmem_we | output | 1 | Data write strobe |
| dmem_rdata | input | 32 | Data read value |
| op_code | output | 6 | Opcode of the held instruction |
| opnd_eq | output | 1 | A equals B |

## Verification
Two updates land on the same clock edge in the final step of an arithmetic, OR-immediate or load instruction: the register-file write and the PC advance. In a store's memory step, the data write and the PC advance also share an edge. The bench drives a random instruction stream through the full step sequence, so these coincident updates happen on almost every instruction. Each one is judged twice. The PC is compared with a reference program counter after every instruction. Every register value is later read back through stores and compared with a reference register array. A lost or doubled update in the shared cycle therefore shows up as a PC or data mismatch.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int INSTR_W = 32;
    localparam int IMM_W   = 16;
    localparam int FN_W    = 6;

    localparam logic [1:0] SEL_FUNCT = 2'b00;
    localparam logic [1:0] SEL_ORZ   = 2'b01;

    localparam logic [FN_W-1:0] FN_ADDU = 6'b100001;
    localparam logic [FN_W-1:0] FN_SUBU = 6'b100011;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_fn_e;

endpackage

// File: rtl/sdp_regfile.sv
module sdp_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] store_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[g] <= '0;
            end else if (we && (wa == AW'(g)) && (g != 0)) begin
                store_q[g] <= wd;
            end
        end
    end

    assign ra_data = store_q[ra_addr];
    assign rb_data = store_q[rb_addr];

    // R9: entry zero stays zero whatever was written
    assert_zero_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == '0) |-> (ra_data == '0));

    // R8: a write to a nonzero entry is visible on the next read of it
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0) && (ra_addr == wa)) |=> (ra_addr != $past(wa)) || (ra_data == $past(wd)));

endmodule

// File: rtl/sdp_alu.sv
module sdp_alu
    import sdp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_fn_e      fn,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (fn)
            ALU_SUB: res = opa - opb;
            ALU_OR:  res = opa | opb;
            default: res = opa + opb;
        endcase
    end

endmodule

// File: rtl/sdp_nextpc.sv
module sdp_nextpc #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [IMM_W-1:0] imm,
    input  logic             br,
    output logic [W-1:0]     pc_next,
    output logic             eq
);

    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] seq_pc;
    logic [W-1:0] offs;

    assign eq      = (a == b);
    assign seq_pc  = pc + STEP;
    assign offs    = {{(W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    assign pc_next = (br && eq) ? (seq_pc + offs) : seq_pc;

endmodule

// File: rtl/staged_dp.sv
module staged_dp
    import sdp_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NREGS    = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ir_ld,
    input  logic            opf_ld,
    input  logic            s_ld,
    input  logic [1:0]      alu_sel,
    input  logic            m_ld,
    input  logic            mem_wr,
    input  logic            rf_we,
    input  logic            rf_wdst,
    input  logic            rf_wsrc,
    input  logic            pc_ld,
    input  logic            pc_br,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [5:0]      op_code,
    output logic            opnd_eq
);

    localparam int RAW = $clog2(NREGS);

    logic [31:0]      ir_q;
    logic [XLEN-1:0]  pc_q, a_q, b_q, s_q, m_q;
    logic [XLEN-1:0]  rs_val, rt_val, alu_b, alu_res, pc_nx, wb_data;
    logic [RAW-1:0]   f_rs, f_rt, f_rd, wb_dst;
    logic [IMM_W-1:0] f_imm;
    logic [FN_W-1:0]  f_fn;
    logic [XLEN-1:0]  imm_zx, imm_sx;
    alu_fn_e          alu_fn;
    logic             ops_equal;

    // instruction fields
    assign f_rs   = RAW'(ir_q[25:21]);
    assign f_rt   = RAW'(ir_q[20:16]);
    assign f_rd   = RAW'(ir_q[15:11]);
    assign f_imm  = ir_q[15:0];
    assign f_fn   = ir_q[5:0];
    assign imm_zx = {{(XLEN-IMM_W){1'b0}}, f_imm};
    assign imm_sx = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

    // ALU operand and function select
    always_comb begin
        unique case (alu_sel)
            SEL_FUNCT: begin
                alu_b  = b_q;
                alu_fn = (f_fn == FN_SUBU) ? ALU_SUB : ALU_ADD;
            end
            SEL_ORZ: begin
                alu_b  = imm_zx;
                alu_fn = ALU_OR;
            end
            default: begin
                alu_b  = imm_sx;
                alu_fn = ALU_ADD;
            end
        endcase
    end

    assign wb_dst  = rf_wdst ? f_rd : f_rt;
    assign wb_data = rf_wsrc ? m_q : s_q;

    sdp_regfile #(.W(XLEN), .DEPTH(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (f_rs),
        .rb_addr (f_rt),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .we      (rf_we),
        .wa      (wb_dst),
        .wd      (wb_data)
    );

    sdp_alu #(.W(XLEN)) u_alu (
        .opa (a_q),
        .opb (alu_b),
        .fn  (alu_fn),
        .res (alu_res)
    );

    sdp_nextpc #(.W(XLEN), .IMM_W(IMM_W)) u_npc (
        .pc      (pc_q),
        .a       (a_q),
        .b       (b_q),
        .imm     (f_imm),
        .br      (pc_br),
        .pc_next (pc_nx),
        .eq      (ops_equal)
    );

    // staging registers, each behind its own enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= XLEN'(RESET_PC);
            ir_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            s_q  <= '0;
            m_q  <= '0;
        end else begin
            if (pc_ld)  pc_q <= pc_nx;
            if (ir_ld)  ir_q <= imem_rdata;
            if (opf_ld) begin
                a_q <= rs_val;
                b_q <= rt_val;
            end
            if (s_ld)   s_q <= alu_res;
            if (m_ld)   m_q <= dmem_rdata;
        end
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = s_q;
    assign dmem_wdata = b_q;
    assign dmem_we    = mem_wr;
    assign op_code    = ir_q[31:26];
    assign opnd_eq    = ops_equal;

    assert_ir_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_ld |=> (op_code == $past(imem_rdata[31:26])));

    assert_pc_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && !pc_br) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    assert_beq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld && pc_br && !opnd_eq) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_ld |=> $stable(imem_addr));

    assert_s_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ld |=> $stable(dmem_addr));

    assert_b_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !opf_ld |=> $stable(dmem_wdata));

    assert_m_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_ld |=> (m_q == $past(dmem_rdata)));

endmodule

// File: tb/test_staged_dp.sv
module test_staged_dp;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ir_ld, opf_ld, s_ld, m_ld, mem_wr, rf_we, rf_wdst, rf_wsrc, pc_ld, pc_br;
    logic [1:0]  alu_sel;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, opnd_eq;
    logic [5:0]  op_code;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic [31:0] ref_rf [32];
    logic [31:0] ref_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [5:0] OP_R = 6'b000000, OP_ORI = 6'b001101, OP_LW = 6'b100011,
                           OP_SW = 6'b101011, OP_BEQ = 6'b000100;

    always #5 clk = ~clk;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    staged_dp i_staged_dp (
        .clk(clk), .rst_n(rst_n), .ir_ld(ir_ld), .opf_ld(opf_ld), .s_ld(s_ld),
        .alu_sel(alu_sel), .m_ld(m_ld), .mem_wr(mem_wr), .rf_we(rf_we),
        .rf_wdst(rf_wdst), .rf_wsrc(rf_wsrc), .pc_ld(pc_ld), .pc_br(pc_br),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
        .op_code(op_code), .opnd_eq(opnd_eq)
    );

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ctl_idle();
        ir_ld = 0; opf_ld = 0; s_ld = 0; alu_sel = 2'b00; m_ld = 0; mem_wr = 0;
        rf_we = 0; rf_wdst = 0; rf_wsrc = 0; pc_ld = 0; pc_br = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        ctl_idle();
    endtask

    task automatic run(input logic [31:0] ins);
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd;
        logic [31:0] a, b, sx, res, ld;
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a = ref_rf[rs]; b = ref_rf[rt]; sx = sx16(ins[15:0]);
        imem[ref_pc[7:2]] = ins;
        ir_ld = 1; tick();
        chk("R2 opcode", {26'd0, op_code}, {26'd0, op});
        opf_ld = 1; tick();
        chk("R3 equality flag", {31'd0, opnd_eq}, {31'd0, a == b});
        case (op)
            OP_R: begin
                s_ld = 1; alu_sel = 2'b00; tick();
                res = (ins[5:0] == 6'b100011) ? a - b : a + b;
                chk("R4 function result", dmem_addr, res);
                rf_we = 1; rf_wdst = 1; pc_ld = 1; tick();
                if (rd != 0) ref_rf[rd] = res;
                ref_pc = ref_pc + 4;
            end
            OP_ORI: begin
                s_ld = 1; alu_sel = 2'b01; tick();
                res = a | {16'd0, ins[15:0]};
                chk("R5 or immediate", dmem_addr, res);
                rf_we = 1; pc_ld = 1; tick();
                if (rt != 0) ref_rf[rt] = res;
                ref_pc = ref_pc + 4;
            end
            OP_LW: begin
                s_ld = 1; alu_sel = ($urandom_range(0, 1) != 0) ? 2'b11 : 2'b10; tick();
                res = a + sx;
                chk("R6 load address", dmem_addr, res);
                ld = dmem[res[7:2]];
                m_ld = 1; tick();
                rf_we = 1; rf_wsrc = 1; pc_ld = 1; tick();
                if (rt != 0) ref_rf[rt] = ld;
                ref_pc = ref_pc + 4;
            end
            OP_SW: begin
                s_ld = 1; alu_sel = 2'b10; tick();
                res = a + sx;
                chk("R6 store address", dmem_addr, res);
                mem_wr = 1; pc_ld = 1; #1;
                chk("R7 write strobe", {31'd0, dmem_we}, 32'd1);
                chk("R7 write data", dmem_wdata, b);
                dmem[dmem_addr[7:2]] = dmem_wdata;
                tick();
                chk("R7 strobe released", {31'd0, dmem_we}, 32'd0);
                ref_pc = ref_pc + 4;
            end
            default: begin
                pc_ld = 1; pc_br = 1; tick();
                ref_pc = (a == b) ? ref_pc + 4 + (sx << 2) : ref_pc + 4;
            end
        endcase
        if (op == OP_BEQ) chk("R11 branch PC", imem_addr, ref_pc);
        else              chk("R10 sequential PC", imem_addr, ref_pc);
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {OP_R, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] fn;
        logic [4:0] s, t;
        logic [31:0] pc_keep, s_keep, b_keep;
        void'($urandom(32'd4242));
        ctl_idle();
        rst_n = 0;
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'd0;
            dmem[i] = $urandom();
        end
        for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
        ref_pc = 32'd0;
        repeat (3) @(negedge clk);
        chk("R1 reset PC", imem_addr, 32'd0);
        chk("R1 reset S", dmem_addr, 32'd0);
        chk("R1 reset B", dmem_wdata, 32'd0);
        chk("R1 reset opcode", {26'd0, op_code}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R9: attempt to write register 0, then read it through a store
        run(enc_i(OP_ORI, 5'd0, 5'd0, 16'hBEEF));
        run(enc_i(OP_SW, 5'd0, 5'd0, 16'd0));
        chk("R9 register zero", dmem[0], 32'd0);

        for (int r = 1; r < 32; r++) run(enc_i(OP_ORI, 5'd0, 5'(r), 16'($urandom())));

        // directed corners: explicit add, subtract, default function, branches both ways
        run(enc_r(5'd1, 5'd2, 5'd3, 6'b100001));
        run(enc_r(5'd1, 5'd2, 5'd4, 6'b100011));
        run(enc_r(5'd4, 5'd1, 5'd5, 6'b000111));
        run(enc_i(OP_BEQ, 5'd6, 5'd6, 16'hFFFF));
        run(enc_i(OP_BEQ, 5'd0, 5'd0, 16'h0010));
        run(enc_i(OP_BEQ, 5'd1, 5'd0, 16'h0020));

        // R12: every enable low while the instruction under the PC changes
        pc_keep = imem_addr; s_keep = dmem_addr; b_keep = dmem_wdata;
        imem[imem_addr[7:2]] = 32'hFFFF_FFFF;
        repeat (3) tick();
        chk("R12 PC held", imem_addr, pc_keep);
        chk("R12 S held", dmem_addr, s_keep);
        chk("R12 B held", dmem_wdata, b_keep);
        chk("R12 IR held", {26'd0, op_code}, {26'd0, OP_BEQ});

        for (int k = 0; k < 400; k++) begin
            s = 5'($urandom()); t = 5'($urandom());
            case ($urandom_range(0, 5))
                0, 5: begin
                    case ($urandom_range(0, 2))
                        0: fn = 6'b100001;
                        1: fn = 6'b100011;
                        default: begin
                            fn = 6'($urandom());
                            if (fn == 6'b100001 || fn == 6'b100011) fn = 6'b100000;
                        end
                    endcase
                    run(enc_r(s, t, 5'($urandom()), fn));
                end
                1: run(enc_i(OP_ORI, s, t, 16'($urandom())));
                2: run(enc_i(OP_LW, s, t, 16'($urandom())));
                3: run(enc_i(OP_SW, s, t, 16'($urandom())));
                default: run(enc_i(OP_BEQ, s, ($urandom_range(0, 1) != 0) ? s : t,
                                   16'($urandom())));
            endcase
        end

        // read back every register through stores at word address r
        for (int r = 0; r < 32; r++) run(enc_i(OP_SW, 5'd0, 5'(r), 16'(r * 4)));
        for (int r = 0; r < 32; r++) begin
            if (r == 0) chk("R9 register zero final", dmem[r], 32'd0);
            else        chk("R8 register write-back", dmem[r], ref_rf[r]);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule